// File: doc/BRIEF.md
# Keystream Core Register Front-End

This block is a word-addressed slave port placed between a host bus and a 20-round-class stream cipher keystream core. The host programs a 256-bit key, a 64-bit nonce, a 512-bit input block, a key-size select and a round count through single-cycle 32-bit accesses. The block holds these values and presents them to the core as wide parallel buses. A write to the command register becomes a one-cycle start pulse toward the core, either "initialise" or "advance to the next block".

On the read side the host can poll a status word that mirrors the core's completion and output-valid flags. It can fetch the 512-bit keystream result as sixteen words, and it can read three fixed ASCII identification words. Every programmable register reads back what was written. Unused addresses read as zero, and a write to an address that holds no writable register is dropped. The cipher arithmetic is not part of this block.

Top module: `stream_cipher_regs`

## Requirements
- R1: While `rstN` is low, the key, nonce, input block, key-size bit, round count and command readback all clear to zero, and `coreInit` and `coreNext` are low.
- R2: Reads of addresses 0x00, 0x01 and 0x02 return the constants "strm" (0x7374726d), "ciph" (0x63697068) and "1.00" (0x312e3030). The first character of each is in bits 31:24.
- R3: The eight key words sit at 0x10 to 0x17. Word k (address 0x10+k) drives `coreKey[255-32k -: 32]`, so 0x10 feeds the most significant word, and each word reads back as written.
- R4: The nonce high word at 0x20 drives `coreIv[63:32]` and the low word at 0x21 drives `coreIv[31:0]`. Both read back as written.
- R5: The sixteen input words sit at 0x40 to 0x4F. Word k drives `coreDataIn[511-32k -: 32]`, and each word reads back as written.
- R6: A read of 0x80+k, for k from 0 to 15, returns `coreDataOut[511-32k -: 32]` as it is in that cycle.
- R7: Bit 0 of the word written to 0x0A sets `coreKeyLen`, and bits 4:0 of the word written to 0x0B set `coreRounds`. The other bits are discarded. Readback shows the stored field with zeros above it.
- R8: A write to 0x08 stores data bits 1:0 for readback. If bit 0 is set, `coreInit` is high for exactly the one cycle after the write edge. If bit 1 is set, `coreNext` is high for exactly that cycle.
- R9: A read of 0x09 returns `coreReady` in bit 0 and `coreDataValid` in bit 1. All other bits are zero.
- R10: Reads of unmapped addresses return zero. Writes to 0x00 to 0x02, 0x09, 0x80 to 0x8F or any unmapped address change no register or core-side output. An access with `sel` low changes nothing.
- R11: `rdData` is combinational and is valid in the same cycle as a read (`sel`=1, `wrEn`=0). At all other times it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Access select, active high |
| wrEn | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational |
| coreInit | output | 1 | One-cycle initialise command |
| coreNext | output | 1 | One-cycle next-block command |
| coreKey | output | 256 | Key to core |
| coreKeyLen | output | 1 | Key size select (0 = 128-bit) |
| coreIv | output | 64 | Nonce to core |
| coreRounds | output | 5 | Round count to core |
| coreDataIn | output | 512 | Input block to core |
| coreReady | input | 1 | Core finished flag |
| coreDataOut | input | 512 | Output block from core |
| coreDataValid | input | 1 | Core output valid flag |

## Verification
Every held register drives a core-side port directly, so a corrupted key, nonce, block or configuration word shows up at the port one edge after the write that caused it. The bench compares these ports against its own model on every clock and does not wait for a readback. A decode fault that sends a write to the wrong word is caught in two places: at that edge, on the wide outputs, and again in a later sweep that reads every address. A wrong command pulse is visible in the cycle right after the command write, because the bench checks the pulse outputs on every clock.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 4;
  localparam int IDENT_WORDS = 3;

  // address anchors; the core-facing word order depends on these bases
  localparam logic [ADDR_W-1:0] IDENT_BASE = 8'h00;
  localparam logic [ADDR_W-1:0] CMD_ADDR   = 8'h08;
  localparam logic [ADDR_W-1:0] STAT_ADDR  = 8'h09;
  localparam logic [ADDR_W-1:0] KLEN_ADDR  = 8'h0A;
  localparam logic [ADDR_W-1:0] RND_ADDR   = 8'h0B;
  localparam logic [ADDR_W-1:0] KEY_BASE   = 8'h10;
  localparam logic [ADDR_W-1:0] IV_BASE    = 8'h20;
  localparam logic [ADDR_W-1:0] DIN_BASE   = 8'h40;
  localparam logic [ADDR_W-1:0] DOUT_BASE  = 8'h80;

  typedef enum logic [3:0] {
    RG_NONE, RG_IDENT, RG_CMD, RG_STAT, RG_KLEN,
    RG_RND, RG_KEY, RG_IV, RG_DIN, RG_DOUT
  } region_e;

  // strobes from the decoder to the register file
  typedef struct packed {
    logic                 wr;
    logic                 rd;
    region_e              rg;
    logic [IDX_W-1:0]     idx;
  } bus_strb_t;
endpackage

// File: rtl/scr_ctrl.sv
`timescale 1ns/1ps
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int KEY_WORDS = 8,
  parameter int IV_WORDS  = 2,
  parameter int BLK_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cmdBits,
  output bus_strb_t         strb,
  output logic              cmdInit,
  output logic              cmdNext
);

  function automatic logic inWin(input logic [ADDR_W-1:0] a,
                                 input logic [ADDR_W-1:0] base,
                                 input int cnt);
    logic [ADDR_W-1:0] off;
    off = a - base;
    return (a >= base) && (int'(off) < cnt);
  endfunction

  region_e           decRg;
  logic [ADDR_W-1:0] decOff;

  always_comb begin
    decRg  = RG_NONE;
    decOff = '0;
    if (inWin(addr, IDENT_BASE, IDENT_WORDS)) begin
      decRg  = RG_IDENT;
      decOff = addr - IDENT_BASE;
    end else if (addr == CMD_ADDR) begin
      decRg = RG_CMD;
    end else if (addr == STAT_ADDR) begin
      decRg = RG_STAT;
    end else if (addr == KLEN_ADDR) begin
      decRg = RG_KLEN;
    end else if (addr == RND_ADDR) begin
      decRg = RG_RND;
    end else if (inWin(addr, KEY_BASE, KEY_WORDS)) begin
      decRg  = RG_KEY;
      decOff = addr - KEY_BASE;
    end else if (inWin(addr, IV_BASE, IV_WORDS)) begin
      decRg  = RG_IV;
      decOff = addr - IV_BASE;
    end else if (inWin(addr, DIN_BASE, BLK_WORDS)) begin
      decRg  = RG_DIN;
      decOff = addr - DIN_BASE;
    end else if (inWin(addr, DOUT_BASE, BLK_WORDS)) begin
      decRg  = RG_DOUT;
      decOff = addr - DOUT_BASE;
    end
  end

  always_comb begin
    strb.wr  = sel && wrEn;
    strb.rd  = sel && !wrEn;
    strb.rg  = decRg;
    strb.idx = decOff[IDX_W-1:0];
  end

  // command pulses: registered, one cycle after the command write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdInit <= 1'b0;
      cmdNext <= 1'b0;
    end else begin
      cmdInit <= strb.wr && (strb.rg == RG_CMD) && cmdBits[0];
      cmdNext <= strb.wr && (strb.rg == RG_CMD) && cmdBits[1];
    end
  end

  AST_INIT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdInit |-> $past(sel && wrEn && addr == CMD_ADDR && cmdBits[0]))
    else $error("init pulse without command write"); // R8
  AST_NEXT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdNext |-> $past(sel && wrEn && addr == CMD_ADDR && cmdBits[1]))
    else $error("next pulse without command write"); // R8
  AST_INIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrEn && addr == CMD_ADDR && cmdBits[0]) |=> cmdInit)
    else $error("init command dropped"); // R8

endmodule

// File: rtl/scr_dpath.sv
`timescale 1ns/1ps
module scr_dpath
  import scr_pkg::*;
#(
  parameter int KEY_WORDS = 8,
  parameter int IV_WORDS  = 2,
  parameter int BLK_WORDS = 16,
  parameter int ROUND_W   = 5,
  parameter logic [WORD_W-1:0] NAME0   = 32'h7374726d,
  parameter logic [WORD_W-1:0] NAME1   = 32'h63697068,
  parameter logic [WORD_W-1:0] VERSION = 32'h312e3030
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bus_strb_t                     strb,
  input  logic [WORD_W-1:0]             wrData,
  input  logic                          coreReady,
  input  logic                          coreValid,
  input  logic [BLK_WORDS*WORD_W-1:0]   coreDataOut,
  output logic [WORD_W-1:0]             rdData,
  output logic [KEY_WORDS*WORD_W-1:0]   keyOut,
  output logic [IV_WORDS*WORD_W-1:0]    ivOut,
  output logic [BLK_WORDS*WORD_W-1:0]   dinOut,
  output logic                          keyLenOut,
  output logic [ROUND_W-1:0]            roundsOut
);

  localparam int KEY_IW = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
  localparam int IV_IW  = (IV_WORDS  > 1) ? $clog2(IV_WORDS)  : 1;
  localparam int BLK_IW = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;

  logic [WORD_W-1:0] keyReg [KEY_WORDS];
  logic [WORD_W-1:0] ivReg  [IV_WORDS];
  logic [WORD_W-1:0] dinReg [BLK_WORDS];
  logic [1:0]        cmdReg;
  logic              keyLenReg;
  logic [ROUND_W-1:0] roundsReg;

  // word 0 of each window lands in the most significant slice
  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) keyReg[i] <= '0;
      else if (strb.wr && strb.rg == RG_KEY && int'(strb.idx) == i) keyReg[i] <= wrData;
    end
    assign keyOut[(KEY_WORDS-1-i)*WORD_W +: WORD_W] = keyReg[i];
  end

  for (genvar i = 0; i < IV_WORDS; i++) begin : g_iv
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ivReg[i] <= '0;
      else if (strb.wr && strb.rg == RG_IV && int'(strb.idx) == i) ivReg[i] <= wrData;
    end
    assign ivOut[(IV_WORDS-1-i)*WORD_W +: WORD_W] = ivReg[i];
  end

  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_din
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dinReg[i] <= '0;
      else if (strb.wr && strb.rg == RG_DIN && int'(strb.idx) == i) dinReg[i] <= wrData;
    end
    assign dinOut[(BLK_WORDS-1-i)*WORD_W +: WORD_W] = dinReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg    <= '0;
      keyLenReg <= 1'b0;
      roundsReg <= '0;
    end else if (strb.wr) begin
      case (strb.rg)
        RG_CMD:  cmdReg    <= wrData[1:0];
        RG_KLEN: keyLenReg <= wrData[0];
        RG_RND:  roundsReg <= wrData[ROUND_W-1:0];
        default: ;
      endcase
    end
  end

  assign keyLenOut = keyLenReg;
  assign roundsOut = roundsReg;

  always_comb begin
    rdData = '0;
    if (strb.rd) begin
      case (strb.rg)
        RG_IDENT: begin
          if (strb.idx == IDX_W'(0))      rdData = NAME0;
          else if (strb.idx == IDX_W'(1)) rdData = NAME1;
          else                            rdData = VERSION;
        end
        RG_CMD:  rdData = WORD_W'(cmdReg);
        RG_STAT: rdData = WORD_W'({coreValid, coreReady});
        RG_KLEN: rdData = WORD_W'(keyLenReg);
        RG_RND:  rdData = WORD_W'(roundsReg);
        RG_KEY:  rdData = keyReg[strb.idx[KEY_IW-1:0]];
        RG_IV:   rdData = ivReg[strb.idx[IV_IW-1:0]];
        RG_DIN:  rdData = dinReg[strb.idx[BLK_IW-1:0]];
        RG_DOUT: rdData = coreDataOut[(BLK_WORDS-1-int'(strb.idx))*WORD_W +: WORD_W];
        default: rdData = '0;
      endcase
    end
  end

  AST_ROUNDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && strb.rg == RG_RND) |=> roundsOut == $past(wrData[ROUND_W-1:0]))
    else $error("round count not loaded"); // R7
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wr |=> $stable(keyOut))
    else $error("key moved without a write"); // R10
  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wr |=> $stable(dinOut))
    else $error("input block moved without a write"); // R10

endmodule

// File: rtl/stream_cipher_regs.sv
`timescale 1ns/1ps
module stream_cipher_regs
  import scr_pkg::*;
#(
  parameter int KEY_WORDS = 8,
  parameter int IV_WORDS  = 2,
  parameter int BLK_WORDS = 16,
  parameter int ROUND_W   = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sel,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [WORD_W-1:0]           wrData,
  output logic [WORD_W-1:0]           rdData,
  output logic                        coreInit,
  output logic                        coreNext,
  output logic [KEY_WORDS*WORD_W-1:0] coreKey,
  output logic                        coreKeyLen,
  output logic [IV_WORDS*WORD_W-1:0]  coreIv,
  output logic [ROUND_W-1:0]          coreRounds,
  output logic [BLK_WORDS*WORD_W-1:0] coreDataIn,
  input  logic                        coreReady,
  input  logic [BLK_WORDS*WORD_W-1:0] coreDataOut,
  input  logic                        coreDataValid
);

  bus_strb_t strb;

  scr_ctrl #(
    .KEY_WORDS(KEY_WORDS), .IV_WORDS(IV_WORDS), .BLK_WORDS(BLK_WORDS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .addr(addr),
    .cmdBits(wrData[1:0]), .strb(strb),
    .cmdInit(coreInit), .cmdNext(coreNext)
  );

  scr_dpath #(
    .KEY_WORDS(KEY_WORDS), .IV_WORDS(IV_WORDS), .BLK_WORDS(BLK_WORDS),
    .ROUND_W(ROUND_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .coreReady(coreReady), .coreValid(coreDataValid), .coreDataOut(coreDataOut),
    .rdData(rdData), .keyOut(coreKey), .ivOut(coreIv), .dinOut(coreDataIn),
    .keyLenOut(coreKeyLen), .roundsOut(coreRounds)
  );

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !(sel && !wrEn) |-> rdData == '0)
    else $error("read data driven outside a read"); // R11

endmodule

// File: tb/sim_stream_cipher_regs.sv
`timescale 1ns/1ps
module sim_stream_cipher_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sel = 1'b0, wrEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic coreInit, coreNext, coreKeyLen;
  logic [255:0] coreKey;
  logic [63:0] coreIv;
  logic [4:0] coreRounds;
  logic [511:0] coreDataIn;
  logic coreReady = 1'b0, coreDataValid = 1'b0;
  logic [511:0] coreDataOut = '0;

  always #10 clk = ~clk; // 50 MHz

  stream_cipher_regs u0 (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .coreInit(coreInit), .coreNext(coreNext),
    .coreKey(coreKey), .coreKeyLen(coreKeyLen), .coreIv(coreIv),
    .coreRounds(coreRounds), .coreDataIn(coreDataIn), .coreReady(coreReady),
    .coreDataOut(coreDataOut), .coreDataValid(coreDataValid)
  );

  int nTests = 0, nFail = 0;
  bit done = 0;

  // behavioural model
  logic [31:0] mKey [8];
  logic [31:0] mIv [2];
  logic [31:0] mDin [16];
  logic mKlen, mInit, mNext;
  logic [4:0] mRnd;
  logic [1:0] mCmd;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mKey[i]) mKey[i] = '0;
      foreach (mIv[i]) mIv[i] = '0;
      foreach (mDin[i]) mDin[i] = '0;
      mKlen = 0; mRnd = '0; mCmd = '0; mInit = 0; mNext = 0;
    end else begin
      mInit = sel && wrEn && addr == 8'h08 && wrData[0];
      mNext = sel && wrEn && addr == 8'h08 && wrData[1];
      if (sel && wrEn) begin
        if (addr == 8'h08) mCmd = wrData[1:0];
        else if (addr == 8'h0A) mKlen = wrData[0];
        else if (addr == 8'h0B) mRnd = wrData[4:0];
        else if (addr >= 8'h10 && addr <= 8'h17) mKey[addr - 8'h10] = wrData;
        else if (addr == 8'h20 || addr == 8'h21) mIv[addr - 8'h20] = wrData;
        else if (addr >= 8'h40 && addr <= 8'h4F) mDin[addr - 8'h40] = wrData;
      end
    end
  end

  function automatic logic [31:0] expRead();
    int a;
    if (!(sel && !wrEn)) return '0;
    a = int'(addr);
    if (a == 0) return "strm";
    if (a == 1) return "ciph";
    if (a == 2) return "1.00";
    if (a == 8) return {30'b0, mCmd};
    if (a == 9) return {30'b0, coreDataValid, coreReady};
    if (a == 10) return {31'b0, mKlen};
    if (a == 11) return {27'b0, mRnd};
    if (a >= 16 && a < 24) return mKey[a-16];
    if (a == 32 || a == 33) return mIv[a-32];
    if (a >= 64 && a < 80) return mDin[a-64];
    if (a >= 128 && a < 144) return coreDataOut[511-32*(a-128) -: 32];
    return '0;
  endfunction

  function automatic string readTag();
    int a;
    if (!rstN) return "R1";
    if (!(sel && !wrEn)) return "R11";
    a = int'(addr);
    if (a <= 2) return "R2";
    if (a == 8) return "R8";
    if (a == 9) return "R9";
    if (a == 10 || a == 11) return "R7";
    if (a >= 16 && a < 24) return "R3";
    if (a == 32 || a == 33) return "R4";
    if (a >= 64 && a < 80) return "R5";
    if (a >= 128 && a < 144) return "R6";
    return "R10";
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [511:0] got, input logic [511:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
    end
  endtask

  // per-clock comparison, sampled 5 ns after the rising edge
  always @(posedge clk) begin
    logic [255:0] eKey;
    logic [63:0] eIv;
    logic [511:0] eDin;
    #5;
    if (!done) begin
      for (int i = 0; i < 8; i++) eKey[255-32*i -: 32] = mKey[i];
      for (int i = 0; i < 2; i++) eIv[63-32*i -: 32] = mIv[i];
      for (int i = 0; i < 16; i++) eDin[511-32*i -: 32] = mDin[i];
      chk(readTag(), "rdData", 512'(rdData), 512'(expRead()));
      chk(rstN ? "R3" : "R1", "coreKey", 512'(coreKey), 512'(eKey));
      chk(rstN ? "R4" : "R1", "coreIv", 512'(coreIv), 512'(eIv));
      chk(rstN ? "R5" : "R1", "coreDataIn", coreDataIn, eDin);
      chk(rstN ? "R7" : "R1", "coreKeyLen", 512'(coreKeyLen), 512'(mKlen));
      chk(rstN ? "R7" : "R1", "coreRounds", 512'(coreRounds), 512'(mRnd));
      chk(rstN ? "R8" : "R1", "coreInit", 512'(coreInit), 512'(mInit));
      chk(rstN ? "R8" : "R1", "coreNext", 512'(coreNext), 512'(mNext));
    end
  end

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wrEn = 1; addr = a; wrData = d;
  endtask
  task automatic busRd(input logic [7:0] a);
    @(negedge clk); sel = 1; wrEn = 0; addr = a; wrData = '0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sel = 0; wrEn = 0; addr = '0; wrData = '0;
    end
  endtask

  function automatic bit writable(input int a);
    return (a >= 8 && a <= 11 && a != 9) || (a >= 16 && a < 24) ||
           a == 32 || a == 33 || (a >= 64 && a < 80);
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state observed during the reset cycles
    repeat (3) @(negedge clk);
    rstN = 1;
    idle(1);
    // R2 identification
    for (int a = 0; a < 3; a++) busRd(8'(a));
    // R3 / R4 / R5 loads and readback
    for (int k = 0; k < 8; k++) busWr(8'h10 + 8'(k), 32'hA5000000 ^ (32'h01020304 * (k + 1)));
    busWr(8'h20, 32'hC0FFEE01);
    busWr(8'h21, 32'h0BADF00D);
    for (int k = 0; k < 16; k++) busWr(8'h40 + 8'(k), 32'h5A5A0000 + 32'(k * 7919));
    for (int k = 0; k < 8; k++) busRd(8'h10 + 8'(k));
    busRd(8'h20); busRd(8'h21);
    for (int k = 0; k < 16; k++) busRd(8'h40 + 8'(k));
    // R7 configuration fields, upper bits discarded
    busWr(8'h0A, 32'hFFFFFFFE); busRd(8'h0A);
    busWr(8'h0A, 32'h00000001); busRd(8'h0A);
    busWr(8'h0B, 32'hFFFFFFF4); busRd(8'h0B);
    busWr(8'h0B, 32'h00000008); busRd(8'h0B);
    // R8 command pulses, including back-to-back and both bits
    busWr(8'h08, 32'h1); busRd(8'h08); busWr(8'h08, 32'h0);
    busWr(8'h08, 32'h2); busWr(8'h08, 32'h2); busRd(8'h08); busWr(8'h08, 32'h0);
    busWr(8'h08, 32'hFFFFFFFF); busRd(8'h08); busWr(8'h08, 32'h0);
    idle(2);
    // R9 / R6 status and output words
    @(negedge clk);
    coreReady = 1; coreDataValid = 0;
    for (int k = 0; k < 16; k++) coreDataOut[511-32*k -: 32] = 32'h10000000 * 32'(k) + 32'h00ABCDEF;
    busRd(8'h09);
    for (int k = 0; k < 16; k++) busRd(8'h80 + 8'(k));
    @(negedge clk);
    coreReady = 0; coreDataValid = 1; coreDataOut = ~coreDataOut;
    busRd(8'h09);
    for (int k = 15; k >= 0; k--) busRd(8'h80 + 8'(k));
    // R10 writes to read-only and unmapped addresses
    for (int a = 0; a < 256; a++)
      if (!writable(a)) busWr(8'(a), 32'hDEAD0000 | 32'(a));
    // R10 access with sel low is ignored
    @(negedge clk); sel = 0; wrEn = 1; addr = 8'h10; wrData = 32'hFFFFFFFF;
    @(negedge clk); sel = 0; wrEn = 1; addr = 8'h08; wrData = 32'h3;
    // R10 / R11 full read sweep
    for (int a = 0; a < 256; a++) busRd(8'(a));
    idle(3);
    done = 1;
    summary();
    $finish;
  end
endmodule